// File: doc/BRIEF.md
# NAND Flash Write-Cycle Strobe Sequencer

This block sequences the control strobes for one external NAND flash bank during a single command, address or data write cycle. A request carries an address, a cycle type and a data byte. The block first checks whether the address belongs to the bank. It compares the address with a base value bit by bit, and only the bits selected by a mask take part. A miss is flagged at once and produces no strobe.

On a hit the block asserts chip-select for a programmable lead time. It then drives the byte and the latch-enable that matches the cycle type. After a programmable setup lag it pulses write-enable low for one bus cycle. Chip-select stays asserted for one more bus cycle, and a done pulse follows.

The sequencer runs on a timing clock at four times the bus rate, so one bus cycle is four ticks and quarter-cycle lags can be placed exactly. Two 2-bit option codes select the lead and the lag from fixed non-linear tables. A per-bank bit suppresses the buffer-control strobe. A page-geometry bit selects the main-area and spare-area byte counts, which the block reports.

Top module: `nand_strobe_seq`

## Requirements
- R1: A request hits when every address bit whose mask bit is 1 equals the matching base bit. Bits with mask 0 are ignored, and the mask may be non-contiguous. An idle request that misses raises `miss` in the same cycle, asserts no strobe and starts no cycle.
- R2: On a hit, `cs_n` goes low on the accepting tick and stays low for a lead, with no bus activity, before the byte is driven. The lead is chosen by {relax, cs_code}: 00 gives 4 ticks, 01 gives 16, 10 gives 8 and 11 gives 32.
- R3: After the lead, the byte and latch-enable are driven, and `we_n` falls after a lag chosen by {relax, cmd_setup_code}: 00 gives 0 ticks, 01 gives 1, 10 gives 2 and 11 gives 4.
- R4: `we_n` stays low for exactly 4 ticks. `bus_data` holds the request byte from the moment it is driven until `cs_n` rises, and reads 0 outside that window.
- R5: `cs_n` stays low for 4 ticks after `we_n` rises, then rises. `done` is then high for exactly 4 ticks, with `cs_n` high.
- R6: When the buffer-control-disable bit is 1, `bctl_n` stays high for the whole access. When the bit is 0, `bctl_n` is low exactly while `cs_n` is low.
- R7: With the page-size bit at 0, `page_main_bytes` is 512 and `page_spare_bytes` is 16. With the bit at 1 they are 2048 and 64.
- R8: `busy` is high from the accepting tick through the last done tick. A request arriving while busy is ignored: it raises no `miss` and does not change the cycle in progress.
- R9: Cycle type 0 (command) raises `cle`, and type 1 (address) raises `ale`. Types 2 and 3 (data) raise neither. The latch-enable is high over the same window as `bus_data`.
- R10: After reset `cs_n`, `we_n` and `bctl_n` are high, and `done`, `busy`, `cle` and `ale` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, four ticks per bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Write-cycle request |
| req_addr | input | ADDR_W | Transaction address |
| req_kind | input | 2 | Cycle type: 0 command, 1 address, 2/3 data |
| req_data | input | 8 | Byte to write |
| base_addr | input | ADDR_W | Bank base address |
| addr_mask | input | ADDR_W | Compare mask, 1 = bit compared |
| opt_relax | input | 1 | Relaxed-timing selector for both tables |
| opt_cs_code | input | 1 | Chip-select lead code |
| opt_cmd_setup | input | 1 | Write-enable lag code |
| opt_bctl_dis | input | 1 | 1 suppresses buffer-control strobe |
| opt_page_large | input | 1 | Page geometry select |
| cs_n | output | 1 | Chip-select, active low |
| we_n | output | 1 | Write-enable, active low |
| bctl_n | output | 1 | Buffer control, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| bus_data | output | 8 | Byte driven to the flash |
| done | output | 1 | End-of-cycle pulse, one bus cycle |
| miss | output | 1 | Request does not address this bank |
| busy | output | 1 | Cycle in progress |
| page_main_bytes | output | 12 | Main-area bytes per page |
| page_spare_bytes | output | 7 | Spare-area bytes per page |

## Verification
`miss` and the geometry outputs are combinational, so they are checked one time step after the inputs change, before the next edge. Every strobe comes from registered state. The bench numbers the falling edges that follow the accepting rising edge from 0. It expects the lead in slots 0 to L-1, the lag in the next S slots, write-enable low for 4 slots, the chip-select hold for 4, done for 4, and idle at slot L+S+12. Each slot is compared on the falling edge, half a tick away from the edge that updates the state, and requests are driven there too. A request made while busy is also checked on the falling edge: `miss` must stay low, and the following slots must still show the original byte.

// File: rtl/nss_pkg.sv
package nss_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_DONE
    } phase_e;

    typedef enum logic [1:0] {
        KIND_CMD  = 2'd0,
        KIND_ADDR = 2'd1,
        KIND_DAT0 = 2'd2,
        KIND_DAT1 = 2'd3
    } kind_e;
endpackage

// File: rtl/nss_bank_match.sv
module nss_bank_match #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    output logic              hit
);
    logic [ADDR_W-1:0] bit_ok;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        // a masked-out bit always agrees
        assign bit_ok[i] = ~mask[i] | ~(addr[i] ^ base[i]);
    end

    assign hit = &bit_ok;
endmodule

// File: rtl/nss_timing_decode.sv
module nss_timing_decode #(
    parameter int TICKS_PER_BUS = 4,
    parameter int CNT_W         = 6
) (
    input  logic             relax,
    input  logic             cs_code,
    input  logic             cmd_code,
    input  logic             page_large,
    output logic [CNT_W-1:0] lead_ticks,
    output logic [CNT_W-1:0] lag_ticks,
    output logic [11:0]      main_bytes,
    output logic [6:0]       spare_bytes
);
    localparam int QTR = TICKS_PER_BUS / 4;

    always_comb begin
        unique case ({relax, cs_code})
            2'b00:   lead_ticks = CNT_W'(1 * TICKS_PER_BUS);
            2'b01:   lead_ticks = CNT_W'(4 * TICKS_PER_BUS);
            2'b10:   lead_ticks = CNT_W'(2 * TICKS_PER_BUS);
            default: lead_ticks = CNT_W'(8 * TICKS_PER_BUS);
        endcase
        unique case ({relax, cmd_code})
            2'b00:   lag_ticks = '0;
            2'b01:   lag_ticks = CNT_W'(1 * QTR);
            2'b10:   lag_ticks = CNT_W'(2 * QTR);
            default: lag_ticks = CNT_W'(4 * QTR);
        endcase
        main_bytes  = page_large ? 12'd2048 : 12'd512;
        spare_bytes = page_large ? 7'd64 : 7'd16;
    end
endmodule

// File: rtl/nss_seq.sv
module nss_seq
    import nss_pkg::*;
#(
    parameter int TICKS_PER_BUS = 4,
    parameter int CNT_W         = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       kind,
    input  logic [7:0]       data,
    input  logic             bctl_dis,
    input  logic [CNT_W-1:0] lead_ticks,
    input  logic [CNT_W-1:0] lag_ticks,
    output logic             cs_n,
    output logic             we_n,
    output logic             bctl_n,
    output logic             cle,
    output logic             ale,
    output logic [7:0]       bus_data,
    output logic             done,
    output logic             busy
);
    localparam logic [CNT_W-1:0] BUS_LAST = CNT_W'(TICKS_PER_BUS - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lag;
        logic [7:0]       data;
        logic [1:0]       kind;
        logic             bctl_dis;
    } seq_t;

    seq_t s_d, s_q;
    logic drive;
    logic cs_act;

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.phase    = PH_LEAD;
                    s_d.cnt      = lead_ticks - 1'b1;
                    s_d.lag      = lag_ticks;
                    s_d.data     = data;
                    s_d.kind     = kind;
                    s_d.bctl_dis = bctl_dis;
                end
            end
            PH_LEAD: begin
                if (s_q.cnt == '0) begin
                    if (s_q.lag == '0) begin
                        s_d.phase = PH_STROBE;
                        s_d.cnt   = BUS_LAST;
                    end else begin
                        s_d.phase = PH_SETUP;
                        s_d.cnt   = s_q.lag - 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_STROBE;
                    s_d.cnt   = BUS_LAST;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_STROBE, PH_HOLD, PH_DONE: begin
                if (s_q.cnt == '0) begin
                    s_d.cnt = BUS_LAST;
                    unique case (s_q.phase)
                        PH_STROBE: s_d.phase = PH_HOLD;
                        PH_HOLD:   s_d.phase = PH_DONE;
                        default:   s_d.phase = PH_IDLE;
                    endcase
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, cnt: '0, lag: '0, data: '0, kind: '0, bctl_dis: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        drive    = (s_q.phase == PH_SETUP) || (s_q.phase == PH_STROBE) || (s_q.phase == PH_HOLD);
        cs_act   = drive || (s_q.phase == PH_LEAD);
        cs_n     = ~cs_act;
        we_n     = (s_q.phase != PH_STROBE);
        bctl_n   = ~(cs_act && !s_q.bctl_dis);
        cle      = drive && (s_q.kind == KIND_CMD);
        ale      = drive && (s_q.kind == KIND_ADDR);
        bus_data = drive ? s_q.data : 8'h00;
        done     = (s_q.phase == PH_DONE);
        busy     = (s_q.phase != PH_IDLE);
    end

    AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !cs_n) else $error("we_n low outside cs_n"); // R4
    AST_WE_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> $stable(bus_data)) else $error("data moved under we_n"); // R4
    AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && we_n)) else $error("done while strobes active"); // R5
    AST_BCTL_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !bctl_n |-> !cs_n) else $error("bctl_n low outside cs_n"); // R6
    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale)) else $error("cle and ale together"); // R9
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> busy) else $error("cycle dropped under request"); // R8
endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq #(
    parameter int ADDR_W        = 16,
    parameter int TICKS_PER_BUS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic [7:0]        req_data,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] addr_mask,
    input  logic              opt_relax,
    input  logic              opt_cs_code,
    input  logic              opt_cmd_setup,
    input  logic              opt_bctl_dis,
    input  logic              opt_page_large,
    output logic              cs_n,
    output logic              we_n,
    output logic              bctl_n,
    output logic              cle,
    output logic              ale,
    output logic [7:0]        bus_data,
    output logic              done,
    output logic              miss,
    output logic              busy,
    output logic [11:0]       page_main_bytes,
    output logic [6:0]        page_spare_bytes
);
    localparam int CNT_W = $clog2(8 * TICKS_PER_BUS + 1);

    logic             hit;
    logic             start;
    logic [CNT_W-1:0] lead_ticks;
    logic [CNT_W-1:0] lag_ticks;

    nss_bank_match #(.ADDR_W(ADDR_W)) u_match (
        .addr (req_addr),
        .base (base_addr),
        .mask (addr_mask),
        .hit  (hit)
    );

    nss_timing_decode #(.TICKS_PER_BUS(TICKS_PER_BUS), .CNT_W(CNT_W)) u_decode (
        .relax       (opt_relax),
        .cs_code     (opt_cs_code),
        .cmd_code    (opt_cmd_setup),
        .page_large  (opt_page_large),
        .lead_ticks  (lead_ticks),
        .lag_ticks   (lag_ticks),
        .main_bytes  (page_main_bytes),
        .spare_bytes (page_spare_bytes)
    );

    assign start = req && hit;
    assign miss  = req && !hit && !busy;

    nss_seq #(.TICKS_PER_BUS(TICKS_PER_BUS), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .kind       (req_kind),
        .data       (req_data),
        .bctl_dis   (opt_bctl_dis),
        .lead_ticks (lead_ticks),
        .lag_ticks  (lag_ticks),
        .cs_n       (cs_n),
        .we_n       (we_n),
        .bctl_n     (bctl_n),
        .cle        (cle),
        .ale        (ale),
        .bus_data   (bus_data),
        .done       (done),
        .busy       (busy)
    );

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (miss && !busy) |=> !busy) else $error("miss started a cycle"); // R1
    AST_HIT_NO_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> !start) else $error("miss and start together"); // R1
    AST_GEOM_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (page_main_bytes == 12'd512) == (page_spare_bytes == 7'd16)) else $error("geometry mismatch"); // R7
endmodule

// File: tb/sim_nand_strobe_seq.sv
module sim_nand_strobe_seq;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_kind = '0;
    logic [7:0]    req_data = '0;
    logic [AW-1:0] base_addr = '0;
    logic [AW-1:0] addr_mask = '0;
    logic          opt_relax = 1'b0, opt_cs_code = 1'b0, opt_cmd_setup = 1'b0;
    logic          opt_bctl_dis = 1'b0, opt_page_large = 1'b0;
    logic          cs_n, we_n, bctl_n, cle, ale, done, miss, busy;
    logic [7:0]    bus_data;
    logic [11:0]   page_main_bytes;
    logic [6:0]    page_spare_bytes;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    nand_strobe_seq #(.ADDR_W(AW), .TICKS_PER_BUS(4)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .req_kind(req_kind),
        .req_data(req_data), .base_addr(base_addr), .addr_mask(addr_mask),
        .opt_relax(opt_relax), .opt_cs_code(opt_cs_code), .opt_cmd_setup(opt_cmd_setup),
        .opt_bctl_dis(opt_bctl_dis), .opt_page_large(opt_page_large),
        .cs_n(cs_n), .we_n(we_n), .bctl_n(bctl_n), .cle(cle), .ale(ale),
        .bus_data(bus_data), .done(done), .miss(miss), .busy(busy),
        .page_main_bytes(page_main_bytes), .page_spare_bytes(page_spare_bytes)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int lead_of(input bit r, input bit c);
        case ({r, c})
            2'b00: return 4;
            2'b01: return 16;
            2'b10: return 8;
            default: return 32;
        endcase
    endfunction

    function automatic int lag_of(input bit r, input bit c);
        case ({r, c})
            2'b00: return 0;
            2'b01: return 1;
            2'b10: return 2;
            default: return 4;
        endcase
    endfunction

    function automatic bit hit_of(input logic [AW-1:0] a, input logic [AW-1:0] b, input logic [AW-1:0] m);
        return ((a ^ b) & m) == '0;
    endfunction

    task automatic chk_geom();
        chk(page_main_bytes == (opt_page_large ? 12'd2048 : 12'd512), "R7 main bytes",
            page_main_bytes, opt_page_large ? 2048 : 512);
        chk(page_spare_bytes == (opt_page_large ? 7'd64 : 7'd16), "R7 spare bytes",
            page_spare_bytes, opt_page_large ? 64 : 16);
    endtask

    // one write request; poke issues a second request while busy
    task automatic run_txn(input logic [AW-1:0] a, input logic [1:0] k, input logic [7:0] d,
                           input bit poke);
        bit h;
        int ld, lg, total;
        bit e_cs, e_we, e_drv, e_done;
        @(negedge clk);
        req = 1'b1; req_addr = a; req_kind = k; req_data = d;
        #1;
        h = hit_of(a, base_addr, addr_mask);
        chk(miss == !h, "R1 miss flag", miss, !h);
        chk_geom();
        if (!h) begin
            @(negedge clk);
            req = 1'b0;
            chk(busy == 1'b0, "R1 miss starts nothing (busy)", busy, 0);
            chk(cs_n == 1'b1 && we_n == 1'b1 && bctl_n == 1'b1, "R1 miss strobes", {cs_n, we_n, bctl_n}, 7);
            return;
        end
        ld = lead_of(opt_relax, opt_cs_code);
        lg = lag_of(opt_relax, opt_cmd_setup);
        total = ld + lg + 12;
        for (int j = 0; j <= total; j++) begin
            @(negedge clk);
            if (j == 0) req = 1'b0;
            e_cs   = (j < ld + lg + 8);
            e_drv  = (j >= ld) && (j < ld + lg + 8);
            e_we   = (j >= ld + lg) && (j < ld + lg + 4);
            e_done = (j >= ld + lg + 8) && (j < total);
            chk(cs_n == !e_cs, "R2 R5 cs_n", cs_n, !e_cs);
            chk(we_n == !e_we, "R3 R4 we_n", we_n, !e_we);
            chk(bctl_n == !(e_cs && !opt_bctl_dis), "R6 bctl_n", bctl_n, !(e_cs && !opt_bctl_dis));
            chk(done == e_done, "R5 done", done, e_done);
            chk(busy == (j < total), "R8 busy", busy, j < total);
            chk(bus_data == (e_drv ? d : 8'h00), "R4 bus_data", bus_data, e_drv ? d : 0);
            chk(cle == (e_drv && k == 2'd0), "R9 cle", cle, e_drv && k == 2'd0);
            chk(ale == (e_drv && k == 2'd1), "R9 ale", ale, e_drv && k == 2'd1);
            if (poke && j == 2) begin
                req = 1'b1; req_addr = base_addr ^ ~addr_mask; req_data = ~d; req_kind = 2'd2;
                #1;
                chk(miss == 1'b0, "R8 no miss while busy", miss, 0);
            end else if (poke && j == 4) begin
                req = 1'b1; req_addr = ~base_addr; req_data = ~d;
                #1;
                chk(miss == 1'b0, "R8 no miss while busy (bad addr)", miss, 0);
            end else if (poke) begin
                req = 1'b0;
            end
        end
    endtask

    initial begin
        logic [AW-1:0] a;
        void'($urandom(32'h5EED_1234));
        #1;
        #40;
        chk(cs_n && we_n && bctl_n, "R10 reset strobes", {cs_n, we_n, bctl_n}, 7);
        chk(!done && !busy && !cle && !ale, "R10 reset flags", {done, busy, cle, ale}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n && !busy, "R10 after release", {cs_n, busy}, 2);

        // directed: every lead/lag code, non-contiguous mask
        base_addr = 16'hA5C3; addr_mask = 16'hF0F0;
        for (int c = 0; c < 4; c++) begin
            {opt_relax, opt_cs_code} = c[1:0];
            opt_cmd_setup = c[0] ^ c[1];
            opt_page_large = c[0];
            opt_bctl_dis = c[1];
            run_txn(16'hA0C0 | 16'h0505, c[1:0], 8'h3C + 8'(c), 1'b0);
        end
        // R2 R3 remaining pairs
        opt_relax = 1'b1; opt_cs_code = 1'b1; opt_cmd_setup = 1'b1; opt_bctl_dis = 1'b0;
        run_txn(16'hAFCF, 2'd0, 8'hE7, 1'b0);
        opt_relax = 1'b0; opt_cs_code = 1'b0; opt_cmd_setup = 1'b0;
        run_txn(16'hA0C0, 2'd1, 8'h81, 1'b0);
        // R1 misses on single compared bits of the non-contiguous mask
        run_txn(16'hA5C3 ^ 16'h1000, 2'd0, 8'h11, 1'b0);
        run_txn(16'hA5C3 ^ 16'h0010, 2'd0, 8'h12, 1'b0);
        // R1 all-zero mask hits anything
        addr_mask = 16'h0000;
        run_txn(16'h1234, 2'd2, 8'h55, 1'b0);
        // R8 requests while busy are ignored
        addr_mask = 16'hFF00; base_addr = 16'h3300;
        opt_relax = 1'b1; opt_cs_code = 1'b0; opt_cmd_setup = 1'b1;
        run_txn(16'h33AB, 2'd1, 8'h9A, 1'b1);

        // random mix
        for (int n = 0; n < 60; n++) begin
            base_addr = AW'($urandom);
            addr_mask = AW'($urandom);
            {opt_relax, opt_cs_code, opt_cmd_setup, opt_bctl_dis, opt_page_large} = 5'($urandom);
            if ($urandom_range(3) != 0)
                a = (base_addr & addr_mask) | (AW'($urandom) & ~addr_mask);
            else
                a = AW'($urandom);
            run_txn(a, 2'($urandom), 8'($urandom), ($urandom_range(4) == 0));
        end

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end
endmodule